// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync pulses, a data-enable strobe and the coordinates of the pixel currently being shown. Every porch, pulse width and active size comes from a small register set written through a single-cycle write port. All timing fields hold the wanted count minus one. A pixel-rate enable is derived from the source clock by a programmable divider, and that divider can be bypassed so that one pixel passes per source clock.

Software first loads the horizontal, vertical and size registers. It then sets the run bit, which starts the counters. The display-enable request is sampled only when the raster wraps back to its first line. A request therefore never cuts into a frame that is already running. The same wrap sets a frame-pending flag, and a clean interrupt can be taken there. That flag drives the interrupt output only while both the global enable and the frame enable are set. Writing a one to the clear register removes it.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, hsync_o and vsync_o are high, de_o and irq_o are low, and x_o and y_o are zero.
- R2: A line is (HS+1)+(HB+1)+(W+1)+(HF+1) pixel steps long. The horizontal register (address 1) holds HS in bits 7:0, HB in bits 15:8 and HF in bits 23:16. The size register (address 3) holds W in bits 11:0. Hsync is active for the first HS+1 steps of each line.
- R3: A frame is (VS+1)+(VB+1)+(H+1)+(VF+1) lines long. The vertical register (address 2) holds VS, VB and VF in the same bit positions as the horizontal register. H sits in bits 27:16 of the size register. Vsync is active for the first VS+1 lines of each frame.
- R4: de_o is high exactly when the horizontal position lies in the W+1 steps after sync and back porch, the vertical position lies in the H+1 lines after sync and back porch, and the display is enabled. x_o and y_o then give the offset from the first active pixel. Outside that window both are zero.
- R5: When the divider-select bit (control bit 2) is set, each pixel step lasts D+1 source cycles, with D in control bits 15:8. When that bit is clear, each step lasts one cycle whatever the value of D.
- R6: While the run bit (control bit 0) is clear, the counters are held at the origin and all outputs stay at their inactive levels.
- R7: The display-enable request (control bit 1) takes effect only when the raster wraps from the last line back to the first. Until that wrap, de_o keeps its previous enable state.
- R8: The frame wrap sets a pending flag whether or not interrupts are enabled. irq_o equals pending AND global enable AND frame enable. The enables are bits 0 and 1 of address 4.
- R9: Writing a one to bit 0 of address 5 clears the pending flag, and writing a zero there leaves it unchanged. If a wrap happens in the same cycle as the clear, the flag stays set.
- R10: Sync outputs are active low. Control bit 3 inverts hsync_o and control bit 4 inverts vsync_o, at both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | 12 | Column within the active area |
| y_o | output | 12 | Row within the active area |
| irq_o | output | 1 | Frame interrupt |

## Verification
The hardest cases to reach are a display-enable request or a pending clear that lands in the middle of a frame. Their effect only shows once the raster wraps. The bench reaches them with a cycle-accurate reference model stepped beside the design. It writes the request partway into a frame and counts every data-enable cycle up to the modelled wrap. It also parks right after a wrap to test the gating and clear writes. Random geometries, divider ratios and polarities from a fixed seed then run whole frames with every output compared on every cycle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    parameter int TG_PW = 8;      // porch and pulse field width
    parameter int TG_CW = 12;     // active size and coordinate width
    parameter int TG_DW = 8;      // divider field width
    parameter int TG_AW = 3;      // register address width
    parameter int TG_XW = 32;     // write data width
    localparam int TG_TW = TG_CW + 2;  // position counter width

    typedef struct packed {
        logic [TG_PW-1:0] sync_m1;
        logic [TG_PW-1:0] bp_m1;
        logic [TG_PW-1:0] fp_m1;
        logic [TG_CW-1:0] act_m1;
    } tg_axis_cfg_t;

    typedef struct packed {
        logic             run;
        logic             show_req;
        logic             div_sel;
        logic             hs_inv;
        logic             vs_inv;
        logic [TG_DW-1:0] div_m1;
    } tg_ctrl_t;

    typedef enum logic [TG_AW-1:0] {
        REG_CTRL = 3'd0,
        REG_HTIM = 3'd1,
        REG_VTIM = 3'd2,
        REG_SIZE = 3'd3,
        REG_IEN  = 3'd4,
        REG_ICLR = 3'd5
    } tg_reg_e;

    function automatic logic [TG_TW-1:0] f_len_p(input logic [TG_PW-1:0] v);
        return TG_TW'(v) + TG_TW'(1);
    endfunction

    function automatic logic [TG_TW-1:0] f_len_c(input logic [TG_CW-1:0] v);
        return TG_TW'(v) + TG_TW'(1);
    endfunction
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TG_AW-1:0] wr_addr,
    input  logic [TG_XW-1:0] wr_data,
    output tg_ctrl_t         ctrl,
    output tg_axis_cfg_t     h_cfg,
    output tg_axis_cfg_t     v_cfg,
    output logic             irq_gen,
    output logic             irq_frm,
    output logic             clr_pulse
);
    logic unused_wr_bits;
    assign unused_wr_bits = &{1'b0, wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            h_cfg   <= '0;
            v_cfg   <= '0;
            irq_gen <= 1'b0;
            irq_frm <= 1'b0;
        end else if (wr_en) begin
            case (tg_reg_e'(wr_addr))
                REG_CTRL: begin
                    ctrl.run      <= wr_data[0];
                    ctrl.show_req <= wr_data[1];
                    ctrl.div_sel  <= wr_data[2];
                    ctrl.hs_inv   <= wr_data[3];
                    ctrl.vs_inv   <= wr_data[4];
                    ctrl.div_m1   <= wr_data[8 +: TG_DW];
                end
                REG_HTIM: begin
                    h_cfg.sync_m1 <= wr_data[0 +: TG_PW];
                    h_cfg.bp_m1   <= wr_data[8 +: TG_PW];
                    h_cfg.fp_m1   <= wr_data[16 +: TG_PW];
                end
                REG_VTIM: begin
                    v_cfg.sync_m1 <= wr_data[0 +: TG_PW];
                    v_cfg.bp_m1   <= wr_data[8 +: TG_PW];
                    v_cfg.fp_m1   <= wr_data[16 +: TG_PW];
                end
                REG_SIZE: begin
                    h_cfg.act_m1 <= wr_data[0 +: TG_CW];
                    v_cfg.act_m1 <= wr_data[16 +: TG_CW];
                end
                REG_IEN: begin
                    irq_gen <= wr_data[0];
                    irq_frm <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    assign clr_pulse = wr_en && (wr_addr == TG_AW'(REG_ICLR)) && wr_data[0];
endmodule

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             div_sel,
    input  logic [TG_DW-1:0] div_m1,
    output logic             tick
);
    logic [TG_DW-1:0] cnt;
    logic             last;

    assign last = (cnt >= div_m1);
    assign tick = run && (!div_sel || last);

    always_ff @(posedge clk) begin
        if (rst || !run || !div_sel) cnt <= '0;
        else if (last)               cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    // R5: with the divider in use, a step is never followed at once by another
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel && div_m1 != '0) |=> (!tick || !div_sel || div_m1 == '0));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  tg_axis_cfg_t     cfg,
    output logic             at_end,
    output logic             in_sync,
    output logic             in_act,
    output logic [TG_CW-1:0] coord
);
    logic [TG_TW-1:0] pos, sw, act_lo, act_hi, total;

    assign sw     = f_len_p(cfg.sync_m1);
    assign act_lo = sw + f_len_p(cfg.bp_m1);
    assign act_hi = act_lo + f_len_c(cfg.act_m1);
    assign total  = act_hi + f_len_p(cfg.fp_m1);

    assign at_end  = (pos >= total - TG_TW'(1));
    assign in_sync = (pos < sw);
    assign in_act  = (pos >= act_lo) && (pos < act_hi);
    assign coord   = in_act ? TG_CW'(pos - act_lo) : '0;

    always_ff @(posedge clk) begin
        if (rst || clr) pos <= '0;
        else if (adv)   pos <= at_end ? '0 : pos + 1'b1;
    end

    // R6: a stopped raster sits at the origin
    a_r6_clear_to_origin: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pos == '0));
    // R2 / R3: the position moves only on a step
    a_r2_r3_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(pos));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TG_AW-1:0] wr_addr,
    input  logic [TG_XW-1:0] wr_data,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [TG_CW-1:0] x_o,
    output logic [TG_CW-1:0] y_o,
    output logic             irq_o
);
    localparam int NAX = 2;  // axis 0 horizontal, axis 1 vertical

    tg_ctrl_t     ctrl;
    tg_axis_cfg_t h_cfg, v_cfg;
    logic         irq_gen, irq_frm, clr_pulse;
    logic         pix_tick, frame_wrap, show_act, pend;

    tg_axis_cfg_t     ax_cfg  [NAX];
    logic             ax_adv  [NAX];
    logic             ax_end  [NAX];
    logic             ax_sync [NAX];
    logic             ax_act  [NAX];
    logic [TG_CW-1:0] ax_crd  [NAX];

    lcd_tg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .h_cfg(h_cfg), .v_cfg(v_cfg),
        .irq_gen(irq_gen), .irq_frm(irq_frm), .clr_pulse(clr_pulse)
    );

    lcd_tg_pixdiv u_div (
        .clk(clk), .rst(rst), .run(ctrl.run), .div_sel(ctrl.div_sel),
        .div_m1(ctrl.div_m1), .tick(pix_tick)
    );

    assign ax_cfg[0] = h_cfg;
    assign ax_cfg[1] = v_cfg;
    assign ax_adv[0] = pix_tick;
    assign ax_adv[1] = pix_tick && ax_end[0];

    generate
        for (genvar a = 0; a < NAX; a++) begin : g_axis
            lcd_tg_axis u_axis (
                .clk(clk), .rst(rst), .clr(!ctrl.run), .adv(ax_adv[a]),
                .cfg(ax_cfg[a]), .at_end(ax_end[a]), .in_sync(ax_sync[a]),
                .in_act(ax_act[a]), .coord(ax_crd[a])
            );
        end
    endgenerate

    assign frame_wrap = pix_tick && ax_end[0] && ax_end[1];

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) show_act <= 1'b0;
        else if (frame_wrap)  show_act <= ctrl.show_req;
    end

    always_ff @(posedge clk) begin
        if (rst)             pend <= 1'b0;
        else if (frame_wrap) pend <= 1'b1;
        else if (clr_pulse)  pend <= 1'b0;
    end

    assign hsync_o = (ctrl.run && ax_sync[0]) ^ ~ctrl.hs_inv;
    assign vsync_o = (ctrl.run && ax_sync[1]) ^ ~ctrl.vs_inv;
    assign de_o    = ctrl.run && show_act && ax_act[0] && ax_act[1];
    assign x_o     = de_o ? ax_crd[0] : '0;
    assign y_o     = de_o ? ax_crd[1] : '0;
    assign irq_o   = pend && irq_gen && irq_frm;

    // R4: data enable never overlaps either sync pulse
    a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (hsync_o != ctrl.hs_inv) && (vsync_o != ctrl.vs_inv));
    // R7: enable state changes only at a frame wrap while running
    a_r7_show_holds_mid_frame: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !frame_wrap) |=> $stable(show_act));
    // R8: pending only rises after a wrap
    a_r8_pend_from_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(frame_wrap));
    // R9: a clear without a simultaneous wrap empties the flag
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !frame_wrap) |=> !pend);
endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, irq_o;
    logic [11:0] x_o, y_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lcd_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
        .irq_o(irq_o)
    );

    // reference model state
    int m_run, m_req, m_sel, m_hinv, m_vinv, m_dm1, m_gie, m_fie;
    int m_hs, m_hb, m_hf, m_hw, m_vs, m_vb, m_vf, m_vh;
    int m_cnt, m_h, m_v, m_show, m_pend, m_wrap;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_run, m_req, m_sel, m_hinv, m_vinv, m_dm1, m_gie, m_fie} = '{default:0};
        {m_hs, m_hb, m_hf, m_hw, m_vs, m_vb, m_vf, m_vh} = '{default:0};
        m_cnt = 0; m_h = 0; m_v = 0; m_show = 0; m_pend = 0; m_wrap = 0;
    endtask

    task automatic model_edge();
        int ht, vt, tick, hend, vend;
        ht = m_hs + m_hb + m_hw + m_hf + 4;
        vt = m_vs + m_vb + m_vh + m_vf + 4;
        tick = m_run && (!m_sel || m_cnt >= m_dm1);
        hend = (m_h >= ht - 1);
        vend = (m_v >= vt - 1);
        m_wrap = tick && hend && vend;
        if (!m_run || !m_sel || m_cnt >= m_dm1) m_cnt = 0; else m_cnt++;
        if (!m_run) begin m_h = 0; m_v = 0; end
        else if (tick) begin
            if (hend) begin m_h = 0; m_v = vend ? 0 : m_v + 1; end
            else m_h++;
        end
        if (!m_run) m_show = 0; else if (m_wrap) m_show = m_req;
        if (m_wrap) m_pend = 1;
        else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_pend = 0;
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin m_run = wr_data[0]; m_req = wr_data[1]; m_sel = wr_data[2];
                            m_hinv = wr_data[3]; m_vinv = wr_data[4]; m_dm1 = wr_data[15:8]; end
                3'd1: begin m_hs = wr_data[7:0]; m_hb = wr_data[15:8]; m_hf = wr_data[23:16]; end
                3'd2: begin m_vs = wr_data[7:0]; m_vb = wr_data[15:8]; m_vf = wr_data[23:16]; end
                3'd3: begin m_hw = wr_data[11:0]; m_vh = wr_data[27:16]; end
                3'd4: begin m_gie = wr_data[0]; m_fie = wr_data[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        int ha, va, hsa, vsa, de, ex, ey;
        ha = m_hs + m_hb + 2;
        va = m_vs + m_vb + 2;
        hsa = m_run && (m_h < m_hs + 1);
        vsa = m_run && (m_v < m_vs + 1);
        de = m_run && m_show && m_h >= ha && m_h < ha + m_hw + 1 && m_v >= va && m_v < va + m_vh + 1;
        ex = de ? m_h - ha : 0;
        ey = de ? m_v - va : 0;
        chk(hsync_o == (m_hinv ? hsa : !hsa), "R2 R10 hsync", hsync_o, m_hinv ? hsa : !hsa);
        chk(vsync_o == (m_vinv ? vsa : !vsa), "R3 R10 vsync", vsync_o, m_vinv ? vsa : !vsa);
        chk(de_o == de, "R4 de", de_o, de);
        chk(x_o == ex && y_o == ey, "R4 coord", {x_o, y_o}, (ex << 12) | ey);
        chk(irq_o == (m_pend && m_gie && m_fie), "R8 irq", irq_o, m_pend && m_gie && m_fie);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
        step();
        wr_en = 1'b0;
    endtask

    function automatic int ctrl_w(int run, int req, int sel, int hi, int vi, int dm1);
        return (dm1 << 8) | (vi << 4) | (hi << 3) | (sel << 2) | (req << 1) | run;
    endfunction

    task automatic wait_wrap();
        for (int i = 0; i < 20000; i++) begin
            step();
            if (m_wrap) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        int seed, lows, des, frame;
        seed = $urandom(32'd7351);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset levels
        chk(hsync_o == 1 && vsync_o == 1, "R1 sync idle", {hsync_o, vsync_o}, 3);
        chk(de_o == 0 && irq_o == 0 && x_o == 0 && y_o == 0, "R1 outputs low", {de_o, irq_o}, 0);

        // directed geometry: line 15 steps, frame 8 lines
        wr(1, (1 << 16) | (2 << 8) | 1);
        wr(2, (0 << 16) | (1 << 8) | 0);
        wr(3, (3 << 16) | 7);
        wr(4, 3);
        wr(0, ctrl_w(1, 1, 0, 0, 0, 0));
        repeat (300) step();

        // R9 and R8 directed, parked just after a wrap
        wait_wrap();
        chk(irq_o == 1, "R8 irq after wrap", irq_o, 1);
        wr(5, 0);
        chk(irq_o == 1, "R9 zero write keeps pending", irq_o, 1);
        wr(5, 1);
        chk(irq_o == 0, "R9 one write clears", irq_o, 0);
        wr(4, 2);
        wait_wrap();
        chk(irq_o == 0, "R8 gated by global enable", irq_o, 0);
        wr(4, 3);
        chk(irq_o == 1, "R8 pending retained", irq_o, 1);
        wr(5, 1);

        // R5: hsync width in source cycles, divider on and bypassed
        for (int pass = 0; pass < 2; pass++) begin
            wr(0, ctrl_w(1, 1, 1 - pass, 0, 0, 2));
            for (int i = 0; i < 2000 && hsync_o == 0; i++) step();
            for (int i = 0; i < 2000 && hsync_o == 1; i++) step();
            lows = 0;
            for (int i = 0; i < 2000 && hsync_o == 0; i++) begin lows++; step(); end
            chk(lows == (pass == 0 ? 6 : 2), "R5 step length", lows, pass == 0 ? 6 : 2);
        end

        // R7: request mid-frame takes effect only at the wrap
        wr(0, ctrl_w(1, 0, 0, 0, 0, 0));
        wait_wrap();
        repeat (20) step();
        wr(0, ctrl_w(1, 1, 0, 0, 0, 0));
        des = 0;
        for (int i = 0; i < 20000; i++) begin
            if (de_o) des++;
            step();
            if (m_wrap) break;
        end
        chk(des == 0, "R7 no de before wrap", des, 0);
        des = 0;
        repeat (120) begin step(); if (de_o) des++; end
        chk(des == 32, "R7 de after wrap", des, 32);

        // R6 and R10: stopped raster, inverted polarities
        wr(0, ctrl_w(0, 1, 0, 1, 1, 0));
        for (int i = 0; i < 5; i++) begin
            step();
            chk(hsync_o == 0 && vsync_o == 0, "R10 inverted idle", {hsync_o, vsync_o}, 0);
            chk(de_o == 0 && x_o == 0 && y_o == 0, "R6 stopped outputs", de_o, 0);
        end

        // random geometries
        for (int it = 0; it < 8; it++) begin
            int hs, hb, hf, hw, vs, vb, vf, vh, sel, dm1;
            hs = $urandom % 4; hb = $urandom % 4; hf = $urandom % 4; hw = $urandom % 8;
            vs = $urandom % 3; vb = $urandom % 3; vf = $urandom % 3; vh = $urandom % 6;
            sel = $urandom % 2; dm1 = $urandom % 4;
            wr(0, 0);
            wr(1, (hf << 16) | (hb << 8) | hs);
            wr(2, (vf << 16) | (vb << 8) | vs);
            wr(3, (vh << 16) | hw);
            wr(4, $urandom % 4);
            wr(0, ctrl_w(1, 1, sel, $urandom % 2, $urandom % 2, dm1));
            frame = (hs + hb + hf + hw + 4) * (vs + vb + vf + vh + 4) * (sel ? dm1 + 1 : 1);
            for (int i = 0; i < 2 * frame + 10; i++) begin
                if (i == frame && ($urandom % 2)) wr(5, 1);
                else step();
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule